// File: doc/BRIEF.md
# Serial Receive Channel with Host-Read Status Queue

This block takes one asynchronous serial receive line and turns it into bytes that a host can read. The line is first passed through a two-register synchronizer. The synchronized copy is the only version of the line that any downstream logic sees. A receiver that samples sixteen times per bit then recovers each character: one start bit, eight data bits with the least significant bit first, and one stop bit. Each recovered character is pushed into a sixteen-entry queue, together with a flag that records whether its stop bit was bad.

The host sees one 16-bit word at all times. The low byte is the character at the head of the queue. The high byte holds status, and its top bit tells the host whether that character is real. A one-cycle read strobe removes the head entry. A strobe issued while the queue is empty leaves the queue untouched, and the host throws that word away. A strobe that lands on the same clock edge as a new character's push keeps both: the head leaves and the new byte enters.

The baud timing comes from outside the block as a single-cycle enable pulse at sixteen times the bit rate. Several copies of this block can share one enable source in a multi-port design.

Top module: `uart_rx_fifo_top`

## Requirements
- R1: The serial input reaches the receive logic only through exactly two clock registers, which reset to the idle (high) level.
- R2: Characters are framed as one low start bit, eight data bits sent least significant bit first, and one stop bit. Each bit is sampled once, near its middle, where the middle is counted in 16x enable pulses.
- R3: A low level on an idle line that has gone high again by the middle of the start bit is ignored. No character is produced, and the receiver still accepts the next valid frame.
- R4: A stop bit sampled low sets that entry's framing-error flag, which is host word bit 13. The byte is still stored. The receiver then waits for the line to return high before it looks for the next start bit.
- R5: The host word is laid out as follows. Bits 7:0 hold the head byte. Bit 15 means data is present. Bit 14 is the sticky overrun flag. Bit 13 is the head entry's framing-error flag. Bits 12:8 hold the number of stored entries.
- R6: The queue holds 16 entries and returns bytes in the order they arrived.
- R7: A new character that arrives while the queue is full and no read is popping is dropped, and the overrun flag is set. Any read strobe clears the overrun flag. A drop on that same edge keeps the flag set.
- R8: A read strobe while bit 15 is clear changes nothing in the queue. The count stays 0, and bits 7:0 and bit 13 read 0 while the queue is empty.
- R9: When a push and a read strobe fall on the same edge with the queue not empty, both take effect and the count is unchanged. No byte is dropped, even when the queue is full.
- R10: After reset the queue is empty, the overrun flag is clear, and the host word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial receive line, idle high |
| baud_x16_en | input | 1 | One-cycle pulse at sixteen times the bit rate |
| host_rd | input | 1 | One-cycle read strobe that pops the head entry |
| host_word | output | 16 | Head byte in bits 7:0 and status in bits 15:8 |

## Verification
The assertions check on every cycle that the receive logic sees the line exactly two clocks late and that the count never goes past sixteen. They also check that a pop and a push on the same edge leave the count unchanged with no drop, that drops happen only when the queue is full and always raise overrun, that empty reads leave the queue empty, and that the status fields agree with each other. Only the bench's scenarios can show that the bits come out in the right order at the right positions, that a short glitch is rejected, and that a bad stop bit is flagged while the byte is still kept. They also show that bytes arriving at random phase, with reads swept across the push edge, all come out in order.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned RX_OSR     = 16;
  localparam int unsigned RX_DEPTH   = 16;
  localparam int unsigned RX_DATA_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic                 ferr;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

  // Level update for one push/pop decision
  function automatic logic [4:0] next_level(input logic [4:0] lvl,
                                            input logic push_ok,
                                            input logic pop_ok);
    logic [4:0] res;
    case ({push_ok, pop_ok})
      2'b10:   res = lvl + 5'd1;
      2'b01:   res = lvl - 5'd1;
      default: res = lvl;
    endcase
    return res;
  endfunction

  // Pointer advance with wrap at the queue depth
  function automatic logic [3:0] next_ptr(input logic [3:0] ptr,
                                          input int unsigned depth);
    logic [3:0] res;
    if (32'(ptr) == depth - 1) res = 4'd0;
    else                       res = ptr + 4'd1;
    return res;
  endfunction

  // Host word assembly
  function automatic logic [15:0] pack_word(input logic present,
                                            input logic ovr,
                                            input logic ferr,
                                            input logic [4:0] lvl,
                                            input logic [7:0] data);
    return {present, ovr, ferr, lvl, data};
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b1;
      dout   <= 1'b1;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR    = RX_OSR,
  parameter int unsigned DATA_W = RX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_ferr
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BW  = $clog2(DATA_W);
  localparam logic [CW-1:0] CONFIRM = CW'(OSR/2 - 2);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_ferr  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!rx) state <= ST_START;
          end
          ST_START: begin
            if (cnt == CONFIRM) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rx, shreg[DATA_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == LASTBIT) state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              byte_valid <= 1'b1;
              byte_data  <= shreg;
              byte_ferr  <= ~rx;
              state      <= rx ? ST_IDLE : ST_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAITHI: begin
            if (rx) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = RX_DEPTH
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  rx_entry_t din,
  output rx_entry_t dout,
  output logic [4:0] level,
  output logic      full,
  output logic      empty,
  output logic      push_ok,
  output logic      pop_ok,
  output logic      drop
);
  localparam int unsigned AW = $clog2(DEPTH);

  rx_entry_t      mem [DEPTH];
  logic [3:0]     wptr;
  logic [3:0]     rptr;

  assign full    = (32'(level) == DEPTH);
  assign empty   = (level == 5'd0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign drop    = push & ~push_ok;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= next_ptr(wptr, DEPTH);
      if (pop_ok)  rptr <= next_ptr(rptr, DEPTH);
      level <= next_level(level, push_ok, pop_ok);
    end
  end
endmodule

// File: rtl/uart_rx_fifo_top.sv
module uart_rx_fifo_top
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR   = RX_OSR,
  parameter int unsigned DEPTH = RX_DEPTH
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_serial,
  input  logic        baud_x16_en,
  input  logic        host_rd,
  output logic [15:0] host_word
);
  logic       rx_s;
  logic       frm_valid;
  logic [7:0] frm_data;
  logic       frm_ferr;
  rx_entry_t  wr_entry;
  rx_entry_t  head;
  logic [4:0] level;
  logic       full;
  logic       empty;
  logic       push_ok;
  logic       pop_ok;
  logic       drop;
  logic       ovr;

  uart_rx_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (rx_s)
  );

  uart_rx_framer #(.OSR(OSR), .DATA_W(8)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_x16_en),
    .rx        (rx_s),
    .byte_valid(frm_valid),
    .byte_data (frm_data),
    .byte_ferr (frm_ferr)
  );

  assign wr_entry = '{ferr: frm_ferr, data: frm_data};

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (frm_valid),
    .pop    (host_rd),
    .din    (wr_entry),
    .dout   (head),
    .level  (level),
    .full   (full),
    .empty  (empty),
    .push_ok(push_ok),
    .pop_ok (pop_ok),
    .drop   (drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (drop)    ovr <= 1'b1;
    else if (host_rd) ovr <= 1'b0;
  end

  assign host_word = pack_word(~empty, ovr,
                               empty ? 1'b0 : head.ferr,
                               level,
                               empty ? 8'h00 : head.data);
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_serial,
  input logic        rx_s,
  input logic        host_rd,
  input logic        push,
  input logic        drop,
  input logic        full,
  input logic        empty,
  input logic [4:0]  level,
  input logic [15:0] host_word
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (rx_s == $past(rx_serial, 2))); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH); // R6

  AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && host_rd && !empty) |=> (level == $past(level))); // R9

  AST_NO_DROP_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !empty) |-> !drop); // R9

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> full); // R7

  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> host_word[14]); // R7

  AST_EMPTY_READ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && empty && !push) |=> (level == 5'd0)); // R8

  AST_PRESENT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    host_word[15] == (host_word[12:8] != 5'd0)); // R5

  AST_EMPTY_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !host_word[15] |-> (host_word[13] == 1'b0 && host_word[7:0] == 8'h00)); // R8
endmodule

bind uart_rx_fifo_top uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_serial(rx_serial),
  .rx_s     (rx_s),
  .host_rd  (host_rd),
  .push     (frm_valid),
  .drop     (drop),
  .full     (full),
  .empty    (empty),
  .level    (level),
  .host_word(host_word)
);

// File: tb/tb_uart_rx_fifo_top.sv
module tb_uart_rx_fifo_top;
  localparam int BIT_CLKS = 64;   // 16 enables x 4 clocks
  localparam int NVEC     = 8;
  // {stop bit level, data}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h155, 9'h1AA, 9'h100, 9'h1FF, 9'h081, 9'h13C, 9'h0C3, 9'h101
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_serial = 1'b1;
  logic        baud_x16_en;
  logic        host_rd = 1'b0;
  logic [15:0] host_word;
  logic [1:0]  div = '0;

  int checks = 0;
  int errors = 0;
  logic [8:0] model [$];   // {ferr, data}

  uart_rx_fifo_top dut (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial),
    .baud_x16_en(baud_x16_en), .host_rd(host_rd), .host_word(host_word)
  );

  always #10 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign baud_x16_en = (div == 2'd3);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_head(input string req);
    logic [8:0] e;
    e = model.pop_front();
    chk(host_word[15] == 1'b1, req, host_word[15], 1);
    chk(host_word[7:0] == e[7:0], req, host_word[7:0], e[7:0]);
    chk(host_word[13] == e[8], req, host_word[13], e[8]);
  endtask

  task automatic pulse_read();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // rd_at >= 0: check head and pulse a read at that clock of the stop bit
  task automatic send_frame(input logic [7:0] d, input logic stop, input int rd_at,
                            input string req);
    logic [9:0] fr;
    fr = {stop, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      rx_serial = fr[b];
      for (int j = 0; j < BIT_CLKS; j++) begin
        if (b == 9 && j == rd_at) begin
          check_head(req);
          host_rd = 1'b1;
        end else begin
          host_rd = 1'b0;
        end
        @(negedge clk);
      end
    end
    host_rd = 1'b0;
    rx_serial = 1'b1;
    model.push_back({~stop, d});
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    chk(host_word == 16'h0000, "R10 reset word", host_word, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      send_frame(VEC[i][7:0], VEC[i][8], -1, "R2");
      chk(host_word[12:8] == 5'd1, "R5 level one", host_word[12:8], 1);
      check_head("R2 R1 R4 data/ferr");
      pulse_read();
      chk(host_word[12:8] == 5'd0, "R5 level after read", host_word[12:8], 0);
    end

    // R3: short low glitch rejected, next frame still received
    rx_serial = 1'b0;
    repeat (16) @(negedge clk);
    rx_serial = 1'b1;
    repeat (5 * BIT_CLKS) @(negedge clk);
    chk(host_word[15] == 1'b0, "R3 glitch ignored", host_word[15], 0);
    send_frame(8'hE7, 1'b1, -1, "R3");
    check_head("R3 frame after glitch");
    pulse_read();

    // R8: read while empty
    chk(host_word == 16'h0000, "R8 empty word", host_word, 0);
    pulse_read();
    chk(host_word == 16'h0000, "R8 after empty read", host_word, 0);
    send_frame(8'h5A, 1'b1, -1, "R8");
    chk(host_word[12:8] == 5'd1, "R8 level after push", host_word[12:8], 1);
    check_head("R8 first byte intact");
    pulse_read();

    // R9: random bytes at random phase, reads swept across the push edge
    for (int p = 0; p < 3; p++) send_frame(8'(8'hA0 + p), 1'b1, -1, "R9 preload");
    for (int k = 0; k < 16; k++) begin
      repeat ($urandom_range(0, 40)) @(negedge clk);
      send_frame(8'($urandom), 1'b1, 24 + k, "R9 aligned read");
      chk(host_word[12:8] == 5'd3, "R9 level kept", host_word[12:8], 3);
    end
    for (int p = 0; p < 3; p++) begin
      check_head("R9 drain");
      pulse_read();
    end
    chk(host_word[15] == 1'b0, "R9 drained empty", host_word[15], 0);

    // R6 R7: fill past capacity
    do_reset();
    for (int i = 0; i < 17; i++) send_frame(8'(8'h10 + i), 1'b1, -1, "R6");
    void'(model.pop_back());  // 17th byte is dropped
    chk(host_word[12:8] == 5'd16, "R6 full level", host_word[12:8], 16);
    chk(host_word[14] == 1'b1, "R7 overrun set", host_word[14], 1);
    check_head("R6 order head");
    pulse_read();
    chk(host_word[14] == 1'b0, "R7 overrun cleared", host_word[14], 0);
    chk(host_word[12:8] == 5'd15, "R7 level after read", host_word[12:8], 15);
    for (int i = 0; i < 15; i++) begin
      check_head("R6 order drain");
      pulse_read();
    end
    chk(host_word == 16'h0000, "R6 empty at end", host_word, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule